// File: doc/BRIEF.md
# SPI Master Transfer Timing Engine

This block is the timing core of an SPI master that talks to a single peripheral. On a start strobe it asserts an active-low chip select, then waits a programmable setup time. It then clocks out a word of 8 to 16 bits, most significant bit first, on a serial clock derived from the system clock by an integer divider. In the same transfer it shifts in the word returned on MISO. Clock polarity and the edge used for capture are selectable. Each transfer ends with a one-cycle done pulse that carries the received word.

After each word, an optional gap counted in 32-clock units is inserted. Chip select is then released, unless the keep flag asks for it to stay active. While chip select is held, a new start goes straight to the first clock edge with no setup wait. A start presented in the done cycle of a transfer with no gap continues the clock without any break in its rhythm. A divider value below two is refused with a one-cycle error pulse. All configuration arrives on plain input ports and is latched when a transfer is accepted.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, spi_cs_n is high, done and cfg_err are low, and from the first clock after reset release spi_sck equals cfg_cpol.
- R2: With divider value D (2..255) one SCK period lasts D clocks. The leading edge is followed by the trailing edge after floor(D/2) clocks, and the trailing edge is followed by the next leading edge after D - floor(D/2) clocks.
- R3: A start while cfg_div is 0 or 1 begins no transfer. It raises cfg_err for exactly one cycle in the cycle after the start is sampled, and spi_cs_n stays high.
- R4: With cfg_setup = 0, the first SCK edge comes floor(D/2) clocks after spi_cs_n falls.
- R5: With cfg_setup = S > 0, the first SCK edge comes S clocks after spi_cs_n falls.
- R6: cfg_len = L (0..8) selects L+8 bits per word, and values above 8 select 16. tx_data is sent MSB first from its low L+8 bits. rx_data holds the received bits right-aligned, with zeros above them.
- R7: SCK idles at cfg_cpol, and the leading edge moves it away from that level. With cfg_cap_lead = 1, MISO and MOSI are captured on leading edges and change on trailing edges. With cfg_cap_lead = 0 they change on leading edges and are captured on trailing edges.
- R8: With cfg_gap = G > 0, chip select is released ceil(D/2) + 32*G clocks after the last SCK edge of the word.
- R9: With cfg_gap = 0, chip select is released ceil(D/2) clocks after the last SCK edge. A start presented in the done cycle produces the next leading edge ceil(D/2) clocks after that last edge, with chip select kept low.
- R10: With cfg_keep_cs = 1, chip select stays low after the transfer until a new start. Such a start produces its first SCK edge in the clock that samples it, with no setup wait.
- R11: done is high for exactly one cycle per transfer, and rx_data is valid in that cycle. A start during setup, shifting or the gap is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request strobe |
| tx_data | input | 16 | Word to send, right-aligned |
| cfg_div | input | 8 | SCK divider, legal 2..255 |
| cfg_setup | input | 8 | Chip-select-to-first-edge delay in clocks, 0 means half period |
| cfg_gap | input | 8 | Post-word gap in units of 32 clocks |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cap_lead | input | 1 | 1: capture on leading edge, 0: capture on trailing edge |
| cfg_len | input | 4 | Word length minus 8 |
| cfg_keep_cs | input | 1 | Keep chip select low after the word |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data in |
| done | output | 1 | One-cycle pulse, received word valid |
| rx_data | output | 16 | Received word, right-aligned |
| cfg_err | output | 1 | One-cycle pulse on a refused start |

## Verification
A wrong segment counter shows up at once as a stretched or shortened SCK half period, or a shifted first edge. The bench measures these distances in clocks from chip-select fall to the first edge, between edges, and from the last edge to release. A wrong half-period index or mode latch surfaces by the end of the word as a bad edge count, a wrong received word or a misplaced done pulse. A wrong end-of-word decision shows up within the gap as chip select released too early, held too long, or a second transfer that was never asked for.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int WORD_MAX = 16;
  localparam int WORD_MIN = 8;
  localparam int CFG_W    = 8;
  localparam int GAP_UNIT = 32;
  localparam int CNT_W    = CFG_W + $clog2(GAP_UNIT) + 1;
  localparam int HALF_W   = $clog2(2 * WORD_MAX);
  localparam int BITS_W   = $clog2(WORD_MAX) + 1;
  localparam int LEN_W    = $clog2(WORD_MAX - WORD_MIN + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_GAP, S_HOLD} eng_state_t;

  // clocks from leading edge to trailing edge
  function automatic logic [CNT_W-1:0] lead_len(input logic [CFG_W-1:0] div);
    return CNT_W'(div >> 1);
  endfunction

  // clocks from trailing edge to next leading edge (or word end)
  function automatic logic [CNT_W-1:0] idle_len(input logic [CFG_W-1:0] div);
    return CNT_W'(div) - CNT_W'(div >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] setup_len(input logic [CFG_W-1:0] setup,
                                                 input logic [CFG_W-1:0] div);
    return (setup == '0) ? lead_len(div) : CNT_W'(setup);
  endfunction

  function automatic logic [CNT_W-1:0] gap_len(input logic [CFG_W-1:0] gap);
    return CNT_W'(gap) * CNT_W'(GAP_UNIT);
  endfunction

  function automatic logic [BITS_W-1:0] word_bits(input logic [LEN_W-1:0] f);
    if (f > LEN_W'(WORD_MAX - WORD_MIN)) return BITS_W'(WORD_MAX);
    return BITS_W'(f) + BITS_W'(WORD_MIN);
  endfunction

  function automatic logic [WORD_MAX-1:0] rx_mask(input logic [BITS_W-1:0] bits);
    logic [WORD_MAX-1:0] m;
    m = '1;
    return m >> (WORD_MAX - int'(bits));
  endfunction
endpackage

// File: rtl/spi_eng_timer.sv
module spi_eng_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic          shift_out,
  input  logic          capture,
  input  logic          miso,
  output logic          mosi,
  output logic [DW-1:0] rx_word
);
  logic [DW-1:0] tx_sr;
  logic [DW-1:0] rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else begin
      if (load)           tx_sr <= load_word;
      else if (shift_out) tx_sr <= {tx_sr[DW-2:0], 1'b0};
      if (load)           rx_sr <= capture ? {{(DW-1){1'b0}}, miso} : '0;
      else if (capture)   rx_sr <= {rx_sr[DW-2:0], miso};
    end
  end

  assign mosi    = tx_sr[DW-1];
  assign rx_word = rx_sr;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [WORD_MAX-1:0] tx_data,
  input  logic [CFG_W-1:0]    cfg_div,
  input  logic [CFG_W-1:0]    cfg_setup,
  input  logic [CFG_W-1:0]    cfg_gap,
  input  logic                cfg_cpol,
  input  logic                cfg_cap_lead,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                cfg_keep_cs,
  output logic                spi_sck,
  output logic                spi_mosi,
  output logic                spi_cs_n,
  input  logic                spi_miso,
  output logic                done,
  output logic [WORD_MAX-1:0] rx_data,
  output logic                cfg_err
);
  eng_state_t         st;
  logic [HALF_W-1:0]  half;
  logic               sck_q, cs_q, err_q;
  logic               c_cpol, c_lead, c_keep;
  logic [CFG_W-1:0]   c_div, c_gap;
  logic [BITS_W-1:0]  c_bits;

  // named internal events
  logic st_idle, st_hold, st_shift;
  logic seg_end, last_half, xfer_end, delay_end, can_start;
  logic start_ok, start_bad, chain, lead_edge, trail_edge;
  logic cap_now, shift_now;
  logic t_load;
  logic [CNT_W-1:0] t_val;
  logic [WORD_MAX-1:0] load_word, rx_raw;

  assign st_idle   = (st == S_IDLE);
  assign st_hold   = (st == S_HOLD);
  assign st_shift  = (st == S_SHIFT);
  assign last_half = ((HALF_W+1)'(half) == (((HALF_W+1)'(c_bits)) << 1) - 1'b1);
  assign xfer_end  = st_shift && seg_end && last_half;
  assign delay_end = ((st == S_GAP) && seg_end) || (xfer_end && (c_gap == '0));
  assign can_start = st_idle || st_hold || delay_end;
  assign start_ok  = start && can_start && (cfg_div > CFG_W'(1));
  assign start_bad = start && can_start && (cfg_div < CFG_W'(2));
  assign chain     = start_ok && !st_idle;

  assign lead_edge  = ((st == S_SETUP) && seg_end) || chain ||
                      (st_shift && seg_end && !last_half && half[0]);
  assign trail_edge = st_shift && seg_end && !half[0];

  assign cap_now   = start_ok ? (chain && cfg_cap_lead)
                              : (c_lead ? lead_edge : trail_edge);
  assign shift_now = !start_ok &&
                     (c_lead ? trail_edge : (lead_edge && (st != S_SETUP)));

  assign load_word = tx_data << (WORD_MAX - int'(word_bits(cfg_len)));

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (start_ok && st_idle) begin
      t_load = 1'b1;
      t_val  = setup_len(cfg_setup, cfg_div) - 1'b1;
    end else if (lead_edge) begin
      t_load = 1'b1;
      t_val  = lead_len(start_ok ? cfg_div : c_div) - 1'b1;
    end else if (trail_edge) begin
      t_load = 1'b1;
      t_val  = idle_len(c_div) - 1'b1;
    end else if (xfer_end && (c_gap != '0)) begin
      t_load = 1'b1;
      t_val  = gap_len(c_gap) - 1'b1;
    end
  end

  spi_eng_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(seg_end)
  );

  spi_eng_shift #(.DW(WORD_MAX)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .load_word(load_word),
    .shift_out(shift_now), .capture(cap_now), .miso(spi_miso),
    .mosi(spi_mosi), .rx_word(rx_raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      half   <= '0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b0;
      err_q  <= 1'b0;
      c_cpol <= 1'b0;
      c_lead <= 1'b0;
      c_keep <= 1'b0;
      c_div  <= '0;
      c_gap  <= '0;
      c_bits <= BITS_W'(WORD_MIN);
    end else begin
      err_q <= start_bad;
      if (start_ok) begin
        c_cpol <= cfg_cpol;
        c_lead <= cfg_cap_lead;
        c_keep <= cfg_keep_cs;
        c_div  <= cfg_div;
        c_gap  <= cfg_gap;
        c_bits <= word_bits(cfg_len);
        cs_q   <= 1'b1;
        half   <= '0;
        if (st_idle) begin
          st    <= S_SETUP;
          sck_q <= cfg_cpol;
        end else begin
          st    <= S_SHIFT;
          sck_q <= ~cfg_cpol;
        end
      end else if (delay_end) begin
        if (c_keep) begin
          st <= S_HOLD;
        end else begin
          st   <= S_IDLE;
          cs_q <= 1'b0;
        end
      end else begin
        case (st)
          S_IDLE:  sck_q <= cfg_cpol;
          S_SETUP: if (seg_end) begin
                     st    <= S_SHIFT;
                     half  <= '0;
                     sck_q <= ~c_cpol;
                   end
          S_SHIFT: if (seg_end) begin
                     if (last_half) begin
                       st <= S_GAP;
                     end else begin
                       half  <= half + 1'b1;
                       sck_q <= ~sck_q;
                     end
                   end
          default: ;
        endcase
      end
    end
  end

  assign spi_sck  = sck_q;
  assign spi_cs_n = ~cs_q;
  assign done     = xfer_end;
  assign rx_data  = rx_raw & rx_mask(c_bits);
  assign cfg_err  = err_q;
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk
  import spi_eng_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CFG_W-1:0]  cfg_div,
  input logic              spi_sck,
  input logic              spi_cs_n,
  input logic              done,
  input logic              cfg_err,
  input logic              st_idle,
  input logic              st_hold,
  input logic              st_shift,
  input logic              lead_edge,
  input logic              trail_edge,
  input logic [HALF_W-1:0] half,
  input logic [BITS_W-1:0] c_bits
);
  a_r1_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> spi_cs_n);

  a_r2_sck_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(spi_sck) && !spi_cs_n && !$past(spi_cs_n)) |-> $past(lead_edge || trail_edge));

  a_r3_err_from_bad_start: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ($past(start) && ($past(cfg_div) < CFG_W'(2))));

  a_r6_half_in_word: assert property (@(posedge clk) disable iff (!rst_n)
    st_shift |-> ((HALF_W+1)'(half) < ((HALF_W+1)'(c_bits) << 1)));

  a_r10_hold_sck_still: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hold && $past(st_hold)) |-> ($stable(spi_sck) && !spi_cs_n));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !spi_cs_n);
endmodule

bind spi_xfer_engine spi_xfer_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_div(cfg_div),
  .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .done(done), .cfg_err(cfg_err),
  .st_idle(st_idle), .st_hold(st_hold), .st_shift(st_shift),
  .lead_edge(lead_edge), .trail_edge(trail_edge), .half(half), .c_bits(c_bits)
);

// File: tb/tb_spi_xfer_engine.sv
module tb_spi_xfer_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] tx_data = '0;
  logic [7:0] cfg_div = 8'd4, cfg_setup = '0, cfg_gap = '0;
  logic cfg_cpol = 1'b0, cfg_cap_lead = 1'b1, cfg_keep_cs = 1'b0;
  logic [3:0] cfg_len = '0;
  logic spi_sck, spi_mosi, spi_cs_n, spi_miso, done, cfg_err;
  logic [15:0] rx_data;

  always #5 clk = ~clk;

  spi_xfer_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
    .cfg_div(cfg_div), .cfg_setup(cfg_setup), .cfg_gap(cfg_gap),
    .cfg_cpol(cfg_cpol), .cfg_cap_lead(cfg_cap_lead), .cfg_len(cfg_len),
    .cfg_keep_cs(cfg_keep_cs), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .done(done),
    .rx_data(rx_data), .cfg_err(cfg_err)
  );

  int tests = 0, fails = 0, cyc = 0;
  int ecyc [0:79];
  logic elead [0:79];
  int en = 0, cs_fall = -1, cs_rise = -1, fall_n = 0, done_n = 0, err_n = 0, mcnt = 0;
  logic [15:0] rxlog [0:3];
  logic [31:0] mrec = '0;
  logic [39:0] sreg = '0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;

  assign spi_miso = sreg[39];

  always @(posedge clk) cyc <= cyc + 1;

  // port monitor and peripheral model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !spi_cs_n) begin cs_fall = cyc; fall_n++; end
      if (!prev_cs && spi_cs_n) cs_rise = cyc;
      if (!spi_cs_n && !prev_cs && spi_sck !== prev_sck) begin
        logic lead;
        lead = (spi_sck != cfg_cpol);
        if (en < 80) begin ecyc[en] = cyc; elead[en] = lead; en++; end
        if (lead == cfg_cap_lead) begin mrec = {mrec[30:0], spi_mosi}; mcnt++; end
        else sreg = sreg << 1;
      end
      if (done && done_n < 4) begin rxlog[done_n] = rx_data; done_n++; end
      if (cfg_err) err_n++;
    end
    prev_sck = spi_sck;
    prev_cs  = spi_cs_n;
  end

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic clear_log();
    en = 0; cs_fall = -1; cs_rise = -1; fall_n = 0; done_n = 0; err_n = 0;
    mcnt = 0; mrec = '0;
  endtask

  task automatic load_slave(input logic lead, input logic [15:0] w1, input int n1,
                            input logic [15:0] w2, input int n2);
    int pos;
    sreg = '0;
    pos = lead ? 39 : 38;
    for (int i = n1 - 1; i >= 0; i--) begin sreg[pos] = w1[i]; pos--; end
    for (int i = n2 - 1; i >= 0; i--) begin sreg[pos] = w2[i]; pos--; end
  endtask

  task automatic set_cfg(input int div, input int setup, input int gap, input logic cpol,
                         input logic lead, input int len, input logic keep);
    @(negedge clk);
    cfg_div = 8'(div); cfg_setup = 8'(setup); cfg_gap = 8'(gap);
    cfg_cpol = cpol; cfg_cap_lead = lead; cfg_len = 4'(len); cfg_keep_cs = keep;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [15:0] d);
    @(negedge clk);
    start = 1'b1; tx_data = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int n);
    for (int i = 0; i < 20000 && done_n < n; i++) @(negedge clk);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 20000 && !spi_cs_n; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // intervals between edges alternate lead->trail = ha, trail->lead = hb
  function automatic int bad_intervals(input int first, input int last, input int ha, input int hb);
    int bad = 0;
    for (int i = first; i < last; i++)
      if (ecyc[i+1] - ecyc[i] != (elead[i] ? ha : hb)) bad++;
    return bad;
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 cs_n after reset", int'(spi_cs_n), 1);
    chk("R1 sck at polarity", int'(spi_sck), int'(cfg_cpol));
    chk("R1 done low", int'(done), 0);
    chk("R1 err low", int'(cfg_err), 0);
  endtask

  task automatic t_basic();
    set_cfg(4, 0, 0, 1'b0, 1'b1, 0, 1'b0);
    clear_log();
    load_slave(1'b1, 16'h3C, 8, 16'h0, 0);
    pulse_start(16'h00A5);
    wait_done(1);
    wait_release();
    chk("R4 default setup = floor(D/2)", ecyc[0] - cs_fall, 2);
    chk("R7 first edge is leading", int'(elead[0]), 1);
    chk("R2 edge count", en, 16);
    chk("R2 half periods D=4", bad_intervals(0, 15, 2, 2), 0);
    chk("R9 release ceil(D/2) after last edge", cs_rise - ecyc[15], 2);
    chk("R6 rx 8-bit", int'(rxlog[0]), 'h3C);
    chk("R6 mosi MSB first", int'(mrec[7:0]), 'hA5);
    chk("R11 one done", done_n, 1);
  endtask

  task automatic t_pol_trail();
    set_cfg(5, 7, 0, 1'b1, 1'b0, 8, 1'b0);
    chk("R7 idle sck follows polarity", int'(spi_sck), 1);
    clear_log();
    load_slave(1'b0, 16'h1234, 16, 16'h0, 0);
    pulse_start(16'hBEEF);
    wait_done(1);
    wait_release();
    chk("R5 programmed setup", ecyc[0] - cs_fall, 7);
    chk("R2 half periods D=5", bad_intervals(0, 31, 2, 3), 0);
    chk("R7 rx trailing capture", int'(rxlog[0]), 'h1234);
    chk("R7 mosi trailing capture", int'(mrec[15:0]), 'hBEEF);
    chk("R7 sck back at polarity", int'(spi_sck), 1);
  endtask

  task automatic t_gap_len12();
    set_cfg(3, 0, 2, 1'b1, 1'b1, 4, 1'b0);
    clear_log();
    load_slave(1'b1, 16'h0ABC, 12, 16'h0, 0);
    pulse_start(16'hF5A3);
    wait_done(1);
    wait_release();
    chk("R4 setup D=3", ecyc[0] - cs_fall, 1);
    chk("R6 edge count 12-bit", en, 24);
    chk("R6 rx zero-extended", int'(rx_data), 'h0ABC);
    chk("R6 mosi low 12 bits", int'(mrec[11:0]), 'h5A3);
    chk("R8 gap 2 units", cs_rise - ecyc[23], 2 + 64);
  endtask

  task automatic t_bad_div();
    set_cfg(0, 0, 0, 1'b0, 1'b1, 0, 1'b0);
    clear_log();
    pulse_start(16'h0011);
    @(negedge clk);
    chk("R3 err pulse div 0", err_n, 1);
    cfg_div = 8'd1;
    pulse_start(16'h0022);
    repeat (20) @(negedge clk);
    chk("R3 err pulse div 1", err_n, 2);
    chk("R3 cs never fell", fall_n, 0);
    chk("R3 no done", done_n, 0);
    chk("R3 err cleared", int'(cfg_err), 0);
  endtask

  task automatic t_busy_ignore();
    set_cfg(4, 0, 1, 1'b0, 1'b1, 0, 1'b0);
    clear_log();
    load_slave(1'b1, 16'h5A, 8, 16'h0, 0);
    pulse_start(16'h0F);
    repeat (6) @(negedge clk);
    pulse_start(16'hFF);
    wait_done(1);
    repeat (5) @(negedge clk);
    pulse_start(16'hFF);
    wait_release();
    repeat (40) @(negedge clk);
    chk("R11 start while busy ignored", done_n, 1);
    chk("R11 no extra edges", en, 16);
    chk("R11 single cs fall", fall_n, 1);
    chk("R8 gap 1 unit", cs_rise - ecyc[15], 2 + 32);
    chk("R11 rx kept", int'(rxlog[0]), 'h5A);
  endtask

  task automatic t_keep();
    int sc;
    set_cfg(4, 3, 0, 1'b0, 1'b0, 0, 1'b1);
    clear_log();
    load_slave(1'b0, 16'h7E, 8, 16'h99, 8);
    pulse_start(16'h81);
    wait_done(1);
    repeat (20) @(negedge clk);
    chk("R10 cs held low", int'(spi_cs_n), 0);
    chk("R10 no release yet", cs_rise, -1);
    cfg_keep_cs = 1'b0;
    @(negedge clk);
    sc = cyc;
    start = 1'b1; tx_data = 16'h42;
    @(negedge clk);
    start = 1'b0;
    wait_done(2);
    wait_release();
    chk("R10 no setup on held start", ecyc[16] - sc, 1);
    chk("R10 first word rx", int'(rxlog[0]), 'h7E);
    chk("R10 second word rx", int'(rxlog[1]), 'h99);
    chk("R10 mosi both words", int'(mrec[15:0]), 'h8142);
    chk("R10 released after second", int'(spi_cs_n), 1);
  endtask

  task automatic t_chain();
    set_cfg(5, 0, 0, 1'b0, 1'b1, 0, 1'b0);
    clear_log();
    load_slave(1'b1, 16'hC3, 8, 16'h18, 8);
    pulse_start(16'h6D);
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    start = 1'b1; tx_data = 16'h92;
    @(negedge clk);
    start = 1'b0;
    wait_done(2);
    wait_release();
    chk("R9 duty kept across words", ecyc[16] - ecyc[15], 3);
    chk("R9 cs stays low between words", fall_n, 1);
    chk("R9 two words", done_n, 2);
    chk("R9 rx chained", int'({rxlog[0][7:0], rxlog[1][7:0]}), 'hC318);
    chk("R9 mosi chained", int'(mrec[15:0]), 'h6D92);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_pol_trail();
    t_gap_len12();
    t_bad_div();
    t_busy_ignore();
    t_keep();
    t_chain();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog R11 act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule